// File: doc/BRIEF.md
# Luma/Chroma Output Bus Formatter

This block accepts one luminance sample and one chrominance sample per pixel and places them on two output buses in one of two arrangements, selected by a mode input. In dual-bus mode, luminance goes to bus A and chrominance goes to bus B, and each pixel produces one qualified output beat. In single-bus mode, bus A carries luminance for the first half of the pixel and chrominance for the second half, bus B is held at zero, and every half-pixel is a qualified beat. Downstream logic registers the buses on cycles where the qualifier enable is high.

The block runs from a clock at twice the pixel rate. An internal phase bit alternates on every cycle. The first cycle after reset is a pixel boundary. The samples, the mode and the narrow-width setting are all captured only at a boundary. A narrow-width input supports 8-bit receivers. In that case the two fractional low bits of each bus are forced to zero, and the eight upper lines carry exactly the bits they would carry in a full-width system.

Top module: `yc_bus_formatter`

## Requirements
- R1: While reset is asserted, and until the first capture, busA, busB and outQual are all zero.
- R2: Dual-bus mode (modeParallel=1). On the cycle after a pixel boundary, busA equals the luma sample and busB equals the chroma sample, with outQual=1. On the following cycle both buses hold those values and outQual=0.
- R3: Single-bus mode (modeParallel=0). On the cycle after a boundary, busA equals the luma sample. On the following cycle, busA equals the chroma sample captured at that same boundary. outQual=1 on both cycles.
- R4: In single-bus mode, busB is zero for the whole pixel.
- R5: With narrow8=1 at the boundary, bits [1:0] of both buses are zero, and bits [9:2] equal bits [9:2] of the corresponding input sample.
- R6: A change of modeParallel or narrow8 between two boundaries has no effect on the output until the cycle after the next boundary.
- R7: The first rising edge after reset release is a boundary, and boundaries recur every second cycle. Changes to lumaIn and chromaIn between boundaries do not reach the buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeParallel | input | 1 | 1 = dual-bus at pixel rate, 0 = single-bus at twice pixel rate |
| narrow8 | input | 1 | 1 = zero the two fractional low bits on both buses |
| lumaIn | input | 10 | Luminance sample for the current pixel |
| chromaIn | input | 10 | Chrominance sample for the current pixel |
| busA | output | 10 | Primary output bus |
| busB | output | 10 | Secondary output bus |
| outQual | output | 1 | Qualifier enable marking valid output beats |

## Verification
The bench sweeps every luma code, paired with a varying chroma code, through all four combinations of mode and width. A design that swapped the halves of a pixel, or that left busB driven in single-bus mode, would show the wrong sample on a checked cycle. A design that fired the qualifier on the second half of a dual-bus pixel would also fail these checks. The bench flips mode, width and both samples in the middle of a pixel. A design that sampled any of them outside the boundary would then change the second-half output early. Under the sweep, a narrow-width design that shifted the data instead of masking the low bits would corrupt bits [9:2].

// File: rtl/yc_fmt_pkg.sv
package yc_fmt_pkg;
  typedef struct packed {
    logic capture;
    logic parallelSel;
    logic emitChroma;
  } ycStrobes_t;
endpackage

// File: rtl/yc_fmt_ctrl.sv
module yc_fmt_ctrl
  import yc_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeParallel,
  output ycStrobes_t strobes,
  output logic       outQual
);
  logic phaseOdd;
  logic parallelHeld;
  logic qualReg;

  always_comb begin
    strobes.capture     = !phaseOdd;
    strobes.parallelSel = modeParallel;
    strobes.emitChroma  = phaseOdd && !parallelHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseOdd     <= 1'b0;
      parallelHeld <= 1'b0;
      qualReg      <= 1'b0;
    end else begin
      phaseOdd <= ~phaseOdd;
      if (strobes.capture) parallelHeld <= modeParallel;
      qualReg <= strobes.capture | strobes.emitChroma;
    end
  end

  assign outQual = qualReg;

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.capture, strobes.emitChroma}));
  p_boundary_alt_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
  p_qual_at_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> outQual);
  p_single_qual_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitChroma |=> outQual);
  p_dual_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && parallelHeld) |=> !outQual);
endmodule

// File: rtl/yc_fmt_datapath.sv
module yc_fmt_datapath
  import yc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int FRAC_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                narrow8,
  input  logic [SAMPLE_W-1:0] lumaIn,
  input  logic [SAMPLE_W-1:0] chromaIn,
  input  ycStrobes_t          strobes,
  output logic [SAMPLE_W-1:0] busA,
  output logic [SAMPLE_W-1:0] busB
);
  localparam int PRIM_W = SAMPLE_W - FRAC_W;

  logic [SAMPLE_W-1:0] fracMask;
  logic [SAMPLE_W-1:0] lumaMasked;
  logic [SAMPLE_W-1:0] chromaMasked;
  logic [SAMPLE_W-1:0] chromaHold;
  logic [SAMPLE_W-1:0] busAReg;
  logic [SAMPLE_W-1:0] busBReg;

  generate
    if (FRAC_W > 0) begin : g_frac
      always_comb fracMask = narrow8 ? {{PRIM_W{1'b1}}, {FRAC_W{1'b0}}} : '1;
    end else begin : g_nofrac
      always_comb fracMask = '1;
    end
  endgenerate

  always_comb begin
    lumaMasked   = lumaIn & fracMask;
    chromaMasked = chromaIn & fracMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAReg    <= '0;
      busBReg    <= '0;
      chromaHold <= '0;
    end else if (strobes.capture) begin
      busAReg    <= lumaMasked;
      busBReg    <= strobes.parallelSel ? chromaMasked : '0;
      chromaHold <= chromaMasked;
    end else if (strobes.emitChroma) begin
      busAReg <= chromaHold;
    end
  end

  assign busA = busAReg;
  assign busB = busBReg;

  p_busb_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.parallelSel) |=> (busB == '0));
  p_chroma_second_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitChroma |=> (busA == $past(chromaHold)));
  p_dual_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.emitChroma) |=> ($stable(busA) && $stable(busB)));
  p_luma_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (busA == ($past(lumaIn) & $past(fracMask))));
  if (FRAC_W > 0) begin : g_narrow_chk
    p_narrow_lsb_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.capture && narrow8) |=> (busA[FRAC_W-1:0] == '0 && busB[FRAC_W-1:0] == '0));
  end
endmodule

// File: rtl/yc_bus_formatter.sv
module yc_bus_formatter
  import yc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int FRAC_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeParallel,
  input  logic                narrow8,
  input  logic [SAMPLE_W-1:0] lumaIn,
  input  logic [SAMPLE_W-1:0] chromaIn,
  output logic [SAMPLE_W-1:0] busA,
  output logic [SAMPLE_W-1:0] busB,
  output logic                outQual
);
  ycStrobes_t strobes;

  yc_fmt_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .modeParallel (modeParallel),
    .strobes      (strobes),
    .outQual      (outQual)
  );

  yc_fmt_datapath #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .narrow8  (narrow8),
    .lumaIn   (lumaIn),
    .chromaIn (chromaIn),
    .strobes  (strobes),
    .busA     (busA),
    .busB     (busB)
  );
endmodule

// File: tb/yc_bus_formatter_tb.sv
module yc_bus_formatter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeParallel = 1'b1;
  logic narrow8 = 1'b0;
  logic [9:0] lumaIn = '0;
  logic [9:0] chromaIn = '0;
  logic [9:0] busA, busB;
  logic outQual;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  yc_bus_formatter dut_i (
    .clk(clk), .rstN(rstN), .modeParallel(modeParallel), .narrow8(narrow8),
    .lumaIn(lumaIn), .chromaIn(chromaIn),
    .busA(busA), .busB(busB), .outQual(outQual)
  );

  function automatic logic [9:0] msk(input logic [9:0] v, input logic nar);
    return nar ? {v[9:2], 2'b00} : v;
  endfunction

  task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One pixel: inputs set at the negedge before the boundary edge.
  // When midFlip is set, the mode, width and samples are changed mid-pixel (R6/R7).
  task automatic pixel(input logic par, input logic nar, input logic [9:0] l,
                       input logic [9:0] c, input bit midFlip, input string req);
    logic [9:0] eB;
    modeParallel = par; narrow8 = nar; lumaIn = l; chromaIn = c;
    @(posedge clk); @(negedge clk);
    eB = par ? msk(c, nar) : 10'd0;
    chk({req, " first half"}, {busA, busB, outQual}, {msk(l, nar), eB, 1'b1});
    if (midFlip) begin
      modeParallel = ~par; narrow8 = ~nar; lumaIn = ~l; chromaIn = ~c;
    end
    @(posedge clk); @(negedge clk);
    chk({req, " second half"}, {busA, busB, outQual},
        {par ? msk(l, nar) : msk(c, nar), eB, ~par});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lumaIn = 10'h3ff; chromaIn = 10'h155;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {busA, busB, outQual}, 21'd0);
    rstN = 1'b1;
    // R7: first edge after release is a boundary
    pixel(1'b1, 1'b0, 10'h2a7, 10'h0c3, 0, "R7 R2 first pixel");
    // R2 R3 R4 R5: sweep all luma codes in each mode/width combination
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 1024; v++) begin
        logic [9:0] cv;
        cv = 10'((v * 7 + 3 + m * 91) % 1024);
        pixel(m[0], m[1], 10'(v), cv, 0,
              m[0] ? (m[1] ? "R2 R5 dual narrow" : "R2 dual")
                   : (m[1] ? "R3 R4 R5 single narrow" : "R3 R4 single"));
      end
    end
    // R6 R7: mid-pixel changes of mode, width and samples
    pixel(1'b1, 1'b0, 10'h1e5, 10'h21b, 1, "R6 R7 dual flip");
    pixel(1'b0, 1'b0, 10'h0f3, 10'h30d, 1, "R6 R7 single flip");
    pixel(1'b0, 1'b1, 10'h3ff, 10'h001, 1, "R6 R5 single narrow flip");
    pixel(1'b1, 1'b1, 10'h002, 10'h3fd, 1, "R6 R5 dual narrow flip");
    pixel(1'b1, 1'b0, 10'h155, 10'h2aa, 0, "R6 after flips");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule